// File: doc/BRIEF.md
# Serially Programmed Four-Channel Output Mode Controller

This block holds two mode bits for each of four output channels and turns them, together with two fast per-channel inputs (data and receive), into a one-hot mode selection. The selection is drive high, drive low, drive termination level, high impedance or low leakage. The mode bits are written through a three-wire serial port, made up of an active-low select, a serial clock and a serial data line. All three serial lines are sampled by a faster system clock.

Each 8-bit frame carries a write-enable mask of four channel bits and one shared pair of mode bits. One frame therefore updates any subset of the channels at once. The reset forces every channel into low leakage. Low leakage overrides the fast inputs in the decode. The mode output is combinational from the stored bits and the live fast inputs, so a data or receive toggle reaches the output in the same cycle.

Top module: `qmode_ctrl`

## Requirements
- R1: A frame is taken most-significant bit first, one bit on each rising edge of `sck` while `sel_n` is low, and it is applied to the channel bits when `sel_n` rises.
- R2: Frame bits 7, 6, 5 and 4 enable writing of channels 0, 1, 2 and 3. A channel whose enable bit is 0 keeps its previous mode bits.
- R3: Frame bit 3 is the low-leakage bit and frame bit 0 is the termination bit, both written to every enabled channel. Frame bits 2 and 1 have no effect.
- R4: While `rst_n` is low at a rising clock edge, every channel's low-leakage bit becomes 1, so every channel outputs low leakage.
- R5: A channel whose low-leakage bit is 1 outputs low leakage, whatever its data, receive and termination values.
- R6: With low leakage off and receive at 0, a channel outputs drive high when its data input is 1 and drive low when it is 0.
- R7: With low leakage off and receive at 1, a channel outputs the termination level when its termination bit is 1 and high impedance when it is 0.
- R8: A frame that ends after fewer than 8 bits changes no channel.
- R9: A frame longer than 8 bits uses the last 8 bits received.
- R10: Each channel's 5-bit mode field is one-hot: bit 0 drive high, bit 1 drive low, bit 2 termination, bit 3 high impedance, bit 4 low leakage. Channel i occupies `mode_out[5*i+4:5*i]`.
- R11: Rising `sck` edges while `sel_n` is high shift nothing into the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Active-low reset, forces low leakage on all channels |
| sel_n | input | 1 | Serial frame select, active low |
| sck | input | 1 | Serial bit clock |
| sdi | input | 1 | Serial data in, MSB first |
| data_in | input | 4 | Per-channel fast data input |
| rcv_in | input | 4 | Per-channel fast receive input |
| mode_out | output | 20 | Per-channel one-hot mode, 5 bits per channel |

## Verification
The assertions assume that the serial lines change slowly compared with `clk`. Each `sck` level and each `sdi` value must be held for several system clocks, so that the two-flop synchronizers never see `sdi` change in the same cycle as an `sck` rise. The stimulus holds every serial level for six clocks, and it changes `sdi` only while `sck` is low. `sel_n` settles well before the first and after the last `sck` edge. The fast data and receive inputs are driven freely, because the decode is combinational and makes no assumption about them.

// File: rtl/qmode_pkg.sv
// Shared constants and mode encoding for the four-channel mode controller.
// Assumes one-hot mode fields of MODE_W bits per channel.
package qmode_pkg;
    localparam int NUM_CH   = 4;
    localparam int FRAME_W  = 8;
    localparam int MODE_W   = 5;
    localparam int LEAK_BIT = 3;
    localparam int TERM_BIT = 0;

    typedef enum logic [MODE_W-1:0] {
        M_HIGH = 5'b00001,
        M_LOW  = 5'b00010,
        M_TERM = 5'b00100,
        M_HIZ  = 5'b01000,
        M_LEAK = 5'b10000
    } mode_e;
endpackage

// File: rtl/qmode_sync.sv
// Two-flop synchronizer for a vector of slow asynchronous inputs.
// Assumes each bit is independent and held for several clk cycles.
module qmode_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two register stages toward the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/qmode_shift.sv
// Serial frame receiver working in the clk domain.
// It detects sck rising edges, shifts sdi MSB first while the select is low,
// and pulses commit for one cycle when the select rises after at least
// FRAME_W bits. Longer frames keep the last FRAME_W bits.
// Assumes synchronized inputs.
module qmode_shift #(
    parameter int FRAME_W = 8,
    localparam int CW     = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_s,
    input  logic               sdi_s,
    input  logic               sel_n_s,
    output logic [FRAME_W-1:0] word,
    output logic               commit
);
    logic          sck_d;
    logic          sel_d;
    logic [CW-1:0] cnt;
    logic          sck_rise;
    logic          sel_rise;

    // Edge detection on the synchronized lines.
    always_comb begin
        sck_rise = sck_s & ~sck_d;
        sel_rise = sel_n_s & ~sel_d;
    end

    // Shift register, saturating bit counter and commit pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d  <= 1'b0;
            sel_d  <= 1'b1;
            cnt    <= '0;
            word   <= '0;
            commit <= 1'b0;
        end else begin
            sck_d  <= sck_s;
            sel_d  <= sel_n_s;
            commit <= 1'b0;
            if (sel_rise) begin
                commit <= (cnt == CW'(FRAME_W));
                cnt    <= '0;
            end else if (sck_rise && !sel_n_s) begin
                word <= {word[FRAME_W-2:0], sdi_s};
                if (cnt != CW'(FRAME_W)) begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/qmode_latch.sv
// Per-channel mode bit storage. On commit, each channel whose enable bit is
// set (frame bit FRAME_W-1-i for channel i) takes the shared leak and term bits.
// Reset sets every leak bit and leaves the term bits alone. Term bits start at 0.
module qmode_latch #(
    parameter int NUM_CH  = 4,
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] word,
    input  logic               commit,
    output logic [NUM_CH-1:0]  leak_q,
    output logic [NUM_CH-1:0]  term_q
);
    import qmode_pkg::*;

    wire unused_bits = ^word[LEAK_BIT-1:TERM_BIT+1];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic term_r = 1'b0;

        // Low-leakage bit, forced on by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                leak_q[i] <= 1'b1;
            end else if (commit && word[FRAME_W-1-i]) begin
                leak_q[i] <= word[LEAK_BIT];
            end
        end

        // Termination bit, not touched by reset.
        always_ff @(posedge clk) begin
            if (commit && rst_n && word[FRAME_W-1-i]) begin
                term_r <= word[TERM_BIT];
            end
        end

        assign term_q[i] = term_r;
    end
endmodule

// File: rtl/qmode_dec.sv
// Combinational mode decode for one channel: leak has the highest priority,
// then receive selects term or high impedance, otherwise data picks high or low.
module qmode_dec (
    input  logic       leak,
    input  logic       term,
    input  logic       data,
    input  logic       rcv,
    output logic [4:0] mode
);
    import qmode_pkg::*;

    // Priority decode to a one-hot mode.
    always_comb begin
        if (leak)      mode = M_LEAK;
        else if (rcv)  mode = term ? M_TERM : M_HIZ;
        else           mode = data ? M_HIGH : M_LOW;
    end
endmodule

// File: rtl/qmode_ctrl.sv
// Top of the serially programmed four-channel output mode controller.
// Synchronizes the serial port, receives frames, stores per-channel mode
// bits and decodes them with the fast data and receive inputs.
module qmode_ctrl #(
    parameter int NUM_CH  = qmode_pkg::NUM_CH,
    parameter int FRAME_W = qmode_pkg::FRAME_W,
    localparam int MW     = qmode_pkg::MODE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_n,
    input  logic                 sck,
    input  logic                 sdi,
    input  logic [NUM_CH-1:0]    data_in,
    input  logic [NUM_CH-1:0]    rcv_in,
    output logic [NUM_CH*MW-1:0] mode_out
);
    logic [2:0]         sync_q;
    logic [FRAME_W-1:0] word;
    logic               commit;
    logic [NUM_CH-1:0]  leak_q;
    logic [NUM_CH-1:0]  term_q;

    qmode_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sel_n, sdi, sck}),
        .q     (sync_q)
    );

    qmode_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_s   (sync_q[0]),
        .sdi_s   (sync_q[1]),
        .sel_n_s (sync_q[2]),
        .word    (word),
        .commit  (commit)
    );

    qmode_latch #(.NUM_CH(NUM_CH), .FRAME_W(FRAME_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .word   (word),
        .commit (commit),
        .leak_q (leak_q),
        .term_q (term_q)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        qmode_dec u_dec (
            .leak (leak_q[i]),
            .term (term_q[i]),
            .data (data_in[i]),
            .rcv  (rcv_in[i]),
            .mode (mode_out[MW*i +: MW])
        );
    end
endmodule

// File: rtl/qmode_ctrl_chk.sv
// Assertion checker for qmode_ctrl, attached with bind.
module qmode_ctrl_chk #(
    parameter int NUM_CH = 4,
    parameter int MW     = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_CH-1:0]    data_in,
    input logic [NUM_CH-1:0]    rcv_in,
    input logic [NUM_CH*MW-1:0] mode_out,
    input logic [NUM_CH-1:0]    leak_q,
    input logic [NUM_CH-1:0]    term_q,
    input logic                 commit
);
    // Leak bits are all set in the first cycle after reset.
    p_reset_leak_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (&leak_q));

    // Stored bits change only on a commit.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(leak_q) && $stable(term_q)));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(mode_out[MW*i +: MW]) == 1);

        p_leak_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
            leak_q[i] |-> mode_out[MW*i + 4]);

        p_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!leak_q[i] && !rcv_in[i]) |-> (mode_out[MW*i] == data_in[i]));

        p_recv_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!leak_q[i] && rcv_in[i]) |-> (mode_out[MW*i + 2] == term_q[i]));
    end
endmodule

bind qmode_ctrl qmode_ctrl_chk #(.NUM_CH(NUM_CH), .MW(MW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_in  (data_in),
    .rcv_in   (rcv_in),
    .mode_out (mode_out),
    .leak_q   (leak_q),
    .term_q   (term_q),
    .commit   (commit)
);

// File: tb/qmode_ctrl_tb_top.sv
module qmode_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic [3:0]  data_in = '0;
    logic [3:0]  rcv_in = '0;
    logic [19:0] mode_out;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    bit m_leak [4];
    bit m_term [4];

    always #2.5 clk = ~clk;

    qmode_ctrl dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n    (sel_n),
        .sck      (sck),
        .sdi      (sdi),
        .data_in  (data_in),
        .rcv_in   (rcv_in),
        .mode_out (mode_out)
    );

    function automatic logic [4:0] exp_mode(bit lk, bit tm, bit d, bit r);
        if (lk) return 5'b10000;
        if (r)  return tm ? 5'b00100 : 5'b01000;
        return d ? 5'b00001 : 5'b00010;
    endfunction

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    // Send the low n bits of v MSB first; update the model for n >= 8 (R1, R9).
    task automatic send_bits(input logic [15:0] v, input int n);
        sel_n = 1'b0;
        wait_clk(6);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = v[i];
            wait_clk(6);
            sck = 1'b1;
            wait_clk(6);
            sck = 1'b0;
        end
        wait_clk(6);
        sel_n = 1'b1;
        wait_clk(12);
        if (n >= 8) begin
            for (int c = 0; c < 4; c++) begin
                if (v[7-c]) begin
                    m_leak[c] = v[3];
                    m_term[c] = v[0];
                end
            end
        end
    endtask

    // Apply one data/receive pattern and compare all channels.
    task automatic apply_check(input logic [3:0] d, input logic [3:0] r, input string tag);
        logic [19:0] exp;
        @(negedge clk);
        data_in = d;
        rcv_in  = r;
        #1;
        for (int c = 0; c < 4; c++) exp[5*c +: 5] = exp_mode(m_leak[c], m_term[c], d[c], r[c]);
        n_vec++;
        if (mode_out !== exp) begin
            n_bad++;
            $display("FAIL %s: mode_out=%h expected=%h (data=%b rcv=%b)", tag, mode_out, exp, d, r);
        end
    endtask

    task automatic sweep(input string tag);
        for (int k = 0; k < 4; k++) apply_check(4'($urandom), 4'($urandom), tag);
        apply_check(4'hF, 4'h0, tag);
        apply_check(4'h0, 4'h0, tag);
        apply_check(4'h0, 4'hF, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wait_clk(4);
        rst_n = 1'b1;
        for (int c = 0; c < 4; c++) m_leak[c] = 1'b1;
        wait_clk(2);
    endtask

    initial begin
        process::self().srandom(32'd1977);
        for (int c = 0; c < 4; c++) begin
            m_leak[c] = 1'b1;
            m_term[c] = 1'b0;
        end
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        sweep("R4 reset state");
        sweep("R5 leak priority");

        send_bits(16'h00F0, 8);          // all channels on, term off
        sweep("R6 drive high/low");
        sweep("R7 high impedance");

        send_bits(16'h00F1, 8);          // all channels on, term on
        sweep("R7 termination");

        send_bits(16'h0088, 8);          // channel 0 back to leak
        sweep("R2 mask keeps others");

        send_bits(16'h0040, 8);          // channel 1 term off
        send_bits(16'h0046, 8);          // channel 1, bits 2 and 1 set
        sweep("R3 ignored bits");

        send_bits(16'h0070, 7);          // short frame
        sweep("R8 short frame");

        send_bits(16'h03A1, 10);         // last 8 bits: A1
        sweep("R9 long frame");

        // Stray sck edges while deselected, then a 7-bit frame.
        for (int i = 0; i < 4; i++) begin
            sdi = 1'b1;
            wait_clk(6);
            sck = 1'b1;
            wait_clk(6);
            sck = 1'b0;
        end
        wait_clk(6);
        send_bits(16'h0079, 7);
        sweep("R11 deselected sck");

        do_reset();
        sweep("R4 mid-run reset");

        for (int f = 0; f < 40; f++) begin
            send_bits(16'($urandom), ($urandom_range(0, 4) == 0) ? 9 : 8);
            sweep("R1 random frame");
            if (f == 20) begin
                do_reset();
                sweep("R4 reset in random run");
            end
        end
        sweep("R10 one-hot field");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule